// File: doc/BRIEF.md
# Control-Line Frame Transmitter

This block is the initiator side of a single-wire, open-drain consumer control bus. A write-only trigger starts a frame. The block pulls the line low for a start bit. For every byte it then sends eight data bits, most significant first, then an end-of-message bit and an acknowledge slot. Every symbol is a low pulse followed by a released interval. The low width and the total width of each symbol come from tick-count configuration inputs. The tick is a clock-enable strobe that sets the time base.

Bytes reach the transmitter through a one-byte holding buffer. The buffer raises a request whenever it is empty. Each byte is loaded together with its end-of-message control bit. While the block releases the line for a logic 1, it reads the line back at the configured sample point. A low reading during the first (header) byte means arbitration was lost. A low reading in a later byte is a transmit error. The block samples the acknowledge slot at the same point. Faults set sticky flags, and each flag has its own write-one clear.

Top module: `ctl_frame_tx`

## Requirements
- R1: After reset, the line is released and `tx_busy`, `ack_bit` and all four `err_flags` are 0. `byte_req` is 1.
- R2: When idle, a `start_trig` pulse makes `tx_busy` and `line_drive_low` go high on the next clock edge. A trigger while busy is ignored.
- R3: The start bit is driven low for `cfg_start_low` ticks and lasts `cfg_start_total` ticks in all.
- R4: Data bits go out most significant first. A 0 is low for `cfg_zero_low` ticks and a 1 for `cfg_one_low` ticks, and each bit lasts `cfg_bit_total` ticks. The loaded end-of-message bit follows, then an acknowledge slot sent as a logic-1 pulse.
- R5: `byte_req` is 1 exactly when the buffer is empty. A `tx_load` while the buffer is full is ignored. The buffer is emptied at the end of the start bit and at the end of each acknowledge slot that continues the frame.
- R6: A byte whose end-of-message bit is 1 ends the frame after its acknowledge slot, and `tx_busy` falls.
- R7: The line is sampled `cfg_ack_sample` ticks after the start of each bit. `ack_bit` holds the level read in the latest acknowledge slot.
- R8: With `direct_addr`=1, a high acknowledge sets `err_flags[0]`. With `direct_addr`=0 (broadcast), a low acknowledge sets it. Either case aborts the frame and empties the buffer.
- R9: If the buffer is empty when the start bit ends, or when a non-final acknowledge slot ends, `err_flags[1]` (underrun) is set and the frame aborts.
- R10: A low line at the sample point of a logic-1 data or end-of-message bit of the first byte sets `err_flags[3]` (arbitration lost). The line is released at that same edge.
- R11: The same mismatch in any later byte sets `err_flags[2]` (transmit error) and aborts the frame.
- R12: Flags are sticky. `err_clr[i]` clears only `err_flags[i]`, and a set in the same cycle wins.
- R13: Bit timing advances only in cycles where `tick` is 1. With `tick` held low, the line level and busy state stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable |
| start_trig | input | 1 | Start-of-frame trigger pulse |
| direct_addr | input | 1 | 1: directly addressed frame, 0: broadcast |
| cfg_start_low | input | CNT_W | Start bit low width, ticks |
| cfg_start_total | input | CNT_W | Start bit total width, ticks |
| cfg_zero_low | input | CNT_W | Logic-0 low width, ticks |
| cfg_one_low | input | CNT_W | Logic-1 low width, ticks |
| cfg_bit_total | input | CNT_W | Data bit total width, ticks |
| cfg_ack_sample | input | CNT_W | Sample point from bit start, ticks |
| tx_data | input | BYTE_W | Byte to load |
| tx_eom | input | 1 | End-of-message bit for the loaded byte |
| tx_load | input | 1 | Load strobe for the holding buffer |
| byte_req | output | 1 | Buffer empty, next byte requested |
| line_in | input | 1 | Level read back from the line |
| line_drive_low | output | 1 | 1 pulls the line low |
| tx_busy | output | 1 | Initiator active |
| ack_bit | output | 1 | Latest sampled acknowledge level |
| err_flags | output | 4 | Sticky flags: [0] ack, [1] underrun, [2] transmit, [3] arbitration |
| err_clr | input | 4 | Write-one clears, same bit order |

## Verification
After reset is released, a trigger shows up as `tx_busy` and a low drive one cycle later. Each symbol then appears as a low pulse whose length in cycles equals its configured low width at a tick every cycle. The next falling edge comes exactly the symbol's total width after the previous one. Sample-point outcomes (the acknowledge level, error flags and the abort) are registered on the same edge that sees the sample, so they are read once `tx_busy` has dropped. The scoreboard measures pulse widths and periods at the falling clock edge, away from the edge where outputs change. The follower model pulls the line low from a symbol's first cycle through its sample point.

// File: rtl/ctl_tx_pkg.sv
package ctl_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_EOM   = 3'd3,
    ST_ACK   = 3'd4
  } tx_state_e;

  localparam int unsigned FLAG_N   = 4;
  localparam int unsigned FLG_ACK  = 0;
  localparam int unsigned FLG_UNDR = 1;
  localparam int unsigned FLG_TXE  = 2;
  localparam int unsigned FLG_ARB  = 3;
endpackage

// File: rtl/ctl_tx_bitgen.sv
module ctl_tx_bitgen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] low_w,
  input  logic [CNT_W-1:0] tot_w,
  input  logic [CNT_W-1:0] samp_w,
  output logic             drive_low,
  output logic             samp_p,
  output logic             end_p
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             at_end, cnt_en;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign at_end  = cnt_inc >= {1'b0, tot_w};
  assign cnt_en  = !run || tick;

  always_comb begin
    if (!run)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign drive_low = run && (cnt_q < low_w);
  assign samp_p    = run && tick && (cnt_q == samp_w);
  assign end_p     = run && tick && at_end;
endmodule

// File: rtl/ctl_tx_holdbuf.sv
module ctl_tx_holdbuf #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              load_eom,
  input  logic              take,
  input  logic              flush,
  output logic              full,
  output logic [BYTE_W-1:0] data,
  output logic              eom
);
  logic full_d, wr_en;

  assign wr_en = load && !full;

  always_comb begin
    full_d = full;
    if (take || flush) full_d = 1'b0;
    else if (wr_en)    full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      eom  <= 1'b0;
    end else if (wr_en) begin
      data <= load_data;
      eom  <= load_eom;
    end
  end
endmodule

// File: rtl/ctl_tx_flags.sv
module ctl_tx_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic nxt, en;
    assign en  = set[i] || clr[i];
    assign nxt = set[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags[i] <= 1'b0;
      else if (en) flags[i] <= nxt;
    end
  end
endmodule

// File: rtl/ctl_frame_tx.sv
module ctl_frame_tx
  import ctl_tx_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_trig,
  input  logic              direct_addr,
  input  logic [CNT_W-1:0]  cfg_start_low,
  input  logic [CNT_W-1:0]  cfg_start_total,
  input  logic [CNT_W-1:0]  cfg_zero_low,
  input  logic [CNT_W-1:0]  cfg_one_low,
  input  logic [CNT_W-1:0]  cfg_bit_total,
  input  logic [CNT_W-1:0]  cfg_ack_sample,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_eom,
  input  logic              tx_load,
  output logic              byte_req,
  input  logic              line_in,
  output logic              line_drive_low,
  output logic              tx_busy,
  output logic              ack_bit,
  output logic [3:0]        err_flags,
  input  logic [3:0]        err_clr
);
  localparam int unsigned IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tx_state_e         state_q, state_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              eom_q, eom_d, first_q, first_d, ack_q, ack_d, ack_en;
  logic              take, flush, abort;
  logic [FLAG_N-1:0] flag_set;
  logic              cur_one, run;
  logic [CNT_W-1:0]  low_sel, tot_sel;
  logic              drv, samp_p, end_p;
  logic              buf_full, buf_eom;
  logic [BYTE_W-1:0] buf_data;

  ctl_tx_holdbuf #(.BYTE_W(BYTE_W)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .load(tx_load), .load_data(tx_data),
    .load_eom(tx_eom), .take(take), .flush(flush), .full(buf_full),
    .data(buf_data), .eom(buf_eom)
  );

  assign run = (state_q != ST_IDLE);

  // current symbol value and its widths
  always_comb begin
    cur_one = 1'b0;
    low_sel = cfg_start_low;
    tot_sel = cfg_start_total;
    case (state_q)
      ST_DATA: cur_one = shreg_q[BYTE_W-1];
      ST_EOM:  cur_one = eom_q;
      ST_ACK:  cur_one = 1'b1;
      default: cur_one = 1'b0;
    endcase
    if (state_q != ST_START) begin
      low_sel = cur_one ? cfg_one_low : cfg_zero_low;
      tot_sel = cfg_bit_total;
    end
  end

  ctl_tx_bitgen #(.CNT_W(CNT_W)) u_bitgen (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .run(run),
    .low_w(low_sel), .tot_w(tot_sel), .samp_w(cfg_ack_sample),
    .drive_low(drv), .samp_p(samp_p), .end_p(end_p)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    shreg_d  = shreg_q;
    idx_d    = idx_q;
    eom_d    = eom_q;
    first_d  = first_q;
    ack_d    = ack_q;
    ack_en   = 1'b0;
    take     = 1'b0;
    flush    = 1'b0;
    abort    = 1'b0;
    flag_set = '0;
    case (state_q)
      ST_IDLE: begin
        if (start_trig) state_d = ST_START;
      end
      ST_START: begin
        if (end_p) begin
          if (buf_full) begin
            take    = 1'b1;
            shreg_d = buf_data;
            eom_d   = buf_eom;
            idx_d   = '0;
            first_d = 1'b1;
            state_d = ST_DATA;
          end else begin
            flag_set[FLG_UNDR] = 1'b1;
            flush   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_DATA, ST_EOM: begin
        if (samp_p && cur_one && !line_in) begin
          abort = 1'b1;
          if (first_q) flag_set[FLG_ARB] = 1'b1;
          else         flag_set[FLG_TXE] = 1'b1;
          flush   = 1'b1;
          state_d = ST_IDLE;
        end
        if (end_p && !abort) begin
          if (state_q == ST_EOM) begin
            state_d = ST_ACK;
          end else begin
            shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
            idx_d   = idx_q + 1'b1;
            if (idx_q == LAST_IDX) state_d = ST_EOM;
          end
        end
      end
      ST_ACK: begin
        if (samp_p) begin
          ack_en = 1'b1;
          ack_d  = line_in;
          if (direct_addr ? line_in : !line_in) begin
            abort = 1'b1;
            flag_set[FLG_ACK] = 1'b1;
            flush   = 1'b1;
            state_d = ST_IDLE;
          end
        end
        if (end_p && !abort) begin
          if (eom_q) begin
            state_d = ST_IDLE;
          end else if (buf_full) begin
            take    = 1'b1;
            shreg_d = buf_data;
            eom_d   = buf_eom;
            idx_d   = '0;
            first_d = 1'b0;
            state_d = ST_DATA;
          end else begin
            flag_set[FLG_UNDR] = 1'b1;
            flush   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      eom_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      eom_q   <= eom_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ack_q <= 1'b0;
    else if (ack_en)  ack_q <= ack_d;
  end

  ctl_tx_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .set(flag_set), .clr(err_clr), .flags(err_flags)
  );

  assign line_drive_low = drv;
  assign tx_busy        = run;
  assign ack_bit        = ack_q;
  assign byte_req       = !buf_full;
endmodule

// File: rtl/ctl_frame_tx_chk.sv
module ctl_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       start_trig,
  input logic       line_drive_low,
  input logic       tx_busy,
  input logic [3:0] err_flags,
  input logic [3:0] err_clr
);
  // R2: an idle trigger is accepted on the next edge
  p_trig_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && start_trig) |=> tx_busy);

  // R2: the line is only pulled while a frame is in progress
  p_drive_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low |-> tx_busy);

  // R12: a flag falls only after its own clear
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_flags) |-> ((~err_flags & $past(err_flags) & ~$past(err_clr)) == 4'b0));

  // R10: arbitration loss releases the line on the same edge
  p_arb_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[3]) |-> (!line_drive_low && !tx_busy));

  // R8: an acknowledge error ends the frame
  p_ack_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[0]) |-> !tx_busy);

  // R13: no tick, no change
  p_tick_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tick) |=> (tx_busy && $stable(line_drive_low)));
endmodule

bind ctl_frame_tx ctl_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start_trig(start_trig),
  .line_drive_low(line_drive_low), .tx_busy(tx_busy),
  .err_flags(err_flags), .err_clr(err_clr)
);

// File: tb/ctl_frame_tx_bench.sv
module ctl_frame_tx_bench;
  localparam int SL = 8, ST = 10, ZL = 5, OL = 2, BT = 7, AS = 4;

  logic       clk = 1'b0;
  logic       rst_n, tick, start_trig, direct_addr, tx_eom, tx_load;
  logic [7:0] tx_data;
  logic [3:0] err_clr;
  logic       byte_req, line_drive_low, tx_busy, ack_bit, line_in;
  logic [3:0] err_flags;

  int n_chk = 0, n_err = 0;
  int q_low[$], q_tot[$];
  string q_req[$];
  bit  pull_mask [0:63];
  bit  mon_en = 1'b1;
  int  follow_cnt = 0, pulse_idx = 0, since_fall = 0, low_len = 0;
  int  last_tot = 0;
  string last_req = "R3";
  logic prev_drv = 1'b0;

  always #4 clk = ~clk;

  assign line_in = !(line_drive_low || (follow_cnt > 0));

  ctl_frame_tx u_ctl_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_trig(start_trig),
    .direct_addr(direct_addr),
    .cfg_start_low(8'(SL)), .cfg_start_total(8'(ST)), .cfg_zero_low(8'(ZL)),
    .cfg_one_low(8'(OL)), .cfg_bit_total(8'(BT)), .cfg_ack_sample(8'(AS)),
    .tx_data(tx_data), .tx_eom(tx_eom), .tx_load(tx_load), .byte_req(byte_req),
    .line_in(line_in), .line_drive_low(line_drive_low), .tx_busy(tx_busy),
    .ack_bit(ack_bit), .err_flags(err_flags), .err_clr(err_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // ---------------- driver side: expected symbols ----------------
  task automatic push_sym(input int low, input int tot, input string req);
    q_low.push_back(low); q_tot.push_back(tot); q_req.push_back(req);
  endtask
  task automatic push_start();
    push_sym(SL, ST, "R3");
  endtask
  task automatic push_bits(input logic [7:0] d, input int n);
    for (int i = 7; i > 7 - n; i--) push_sym(d[i] ? OL : ZL, BT, "R4");
  endtask
  task automatic push_byte(input logic [7:0] d, input bit eom);
    push_bits(d, 8);
    push_sym(eom ? OL : ZL, BT, "R4");
    push_sym(OL, BT, "R4");
  endtask

  task automatic clear_pulls();
    for (int i = 0; i < 64; i++) pull_mask[i] = 1'b0;
  endtask

  task automatic load_byte(input logic [7:0] d, input bit eom);
    @(negedge clk); tx_data = d; tx_eom = eom; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic trigger();
    @(negedge clk); start_trig = 1'b1;
    @(negedge clk); start_trig = 1'b0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 500 && !byte_req; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && tx_busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_drained(input string req);
    chk(q_low.size() == 0, req, q_low.size(), 0);
    q_low.delete(); q_tot.delete(); q_req.delete();
  endtask

  task automatic clear_flags();
    @(negedge clk); err_clr = 4'hF;
    @(negedge clk); err_clr = 4'h0;
  endtask

  // ---------------- monitor: pulse widths, periods, follower ----------------
  always @(negedge clk) begin
    if (follow_cnt > 0) follow_cnt--;
    since_fall++;
    low_len++;
    if (!tx_busy && !line_drive_low) pulse_idx = 0;
    if (line_drive_low && !prev_drv) begin
      if (mon_en && pulse_idx > 0) chk(since_fall == last_tot, last_req, since_fall, last_tot);
      since_fall = 0;
      low_len = 0;
      if (pulse_idx < 64 && pull_mask[pulse_idx]) follow_cnt = 5;
    end
    if (!line_drive_low && prev_drv) begin
      if (mon_en) begin
        if (q_low.size() == 0) begin
          chk(1'b0, "R4", low_len, -1);
        end else begin
          int el;
          el = q_low.pop_front();
          last_tot = q_tot.pop_front();
          last_req = q_req.pop_front();
          chk(low_len == el, last_req, low_len, el);
        end
      end
      pulse_idx++;
    end
    prev_drv = line_drive_low;
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    clear_pulls();
    rst_n = 1'b0; tick = 1'b1; start_trig = 1'b0; direct_addr = 1'b1;
    tx_eom = 1'b0; tx_load = 1'b0; tx_data = 8'h00; err_clr = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(!tx_busy && !line_drive_low, "R1", int'(tx_busy), 0);
    chk(err_flags == 4'h0, "R1", int'(err_flags), 0);
    chk(byte_req && !ack_bit, "R1", int'(byte_req), 1);

    // two-byte direct frame, acknowledged; R2 R3 R4 R5 R6 R7
    direct_addr = 1'b1;
    pull_mask[10] = 1'b1; pull_mask[20] = 1'b1;
    load_byte(8'hA5, 1'b0);
    chk(!byte_req, "R5", int'(byte_req), 0);
    load_byte(8'h11, 1'b1);                 // buffer full: ignored (R5)
    push_start(); push_byte(8'hA5, 1'b0); push_byte(8'h3C, 1'b1);
    @(negedge clk); start_trig = 1'b1;
    @(negedge clk); start_trig = 1'b0;
    chk(tx_busy && line_drive_low, "R2", int'(tx_busy), 1);
    wait_req();
    load_byte(8'h3C, 1'b1);
    trigger();                              // ignored while busy (R2)
    wait_idle();
    check_drained("R6");
    chk(err_flags == 4'h0, "R6", int'(err_flags), 0);
    chk(ack_bit == 1'b0, "R7", int'(ack_bit), 0);
    clear_pulls();

    // broadcast, nobody pulls ack: no error (R8), ack level high (R7)
    direct_addr = 1'b0;
    load_byte(8'h0F, 1'b1);
    push_start(); push_byte(8'h0F, 1'b1);
    trigger(); wait_idle();
    check_drained("R8");
    chk(err_flags == 4'h0, "R8", int'(err_flags), 0);
    chk(ack_bit == 1'b1, "R7", int'(ack_bit), 1);

    // broadcast refused (ack low): ack error R8
    pull_mask[10] = 1'b1;
    load_byte(8'h70, 1'b1);
    push_start(); push_byte(8'h70, 1'b1);
    trigger(); wait_idle();
    check_drained("R8");
    chk(err_flags == 4'b0001, "R8", int'(err_flags), 1);
    clear_pulls();

    // R12: other bit's clear leaves the flag, its own clear removes it
    @(negedge clk); err_clr = 4'b0010;
    @(negedge clk); err_clr = 4'b0000;
    chk(err_flags == 4'b0001, "R12", int'(err_flags), 1);
    @(negedge clk); err_clr = 4'b0001;
    @(negedge clk); err_clr = 4'b0000;
    chk(err_flags == 4'b0000, "R12", int'(err_flags), 0);

    // direct, not acknowledged: abort and flush (R8)
    direct_addr = 1'b1;
    load_byte(8'h3C, 1'b0);
    push_start(); push_byte(8'h3C, 1'b0);
    trigger(); wait_req();
    load_byte(8'h99, 1'b1);
    wait_idle();
    check_drained("R8");
    chk(err_flags == 4'b0001, "R8", int'(err_flags), 1);
    chk(byte_req == 1'b1, "R8", int'(byte_req), 1);
    clear_flags();

    // underrun at end of start bit (R9)
    push_start();
    trigger(); wait_idle();
    check_drained("R9");
    chk(err_flags == 4'b0010, "R9", int'(err_flags), 2);
    clear_flags();

    // underrun after a continuing ack slot (R9)
    pull_mask[10] = 1'b1;
    load_byte(8'h00, 1'b0);
    push_start(); push_byte(8'h00, 1'b0);
    trigger(); wait_idle();
    check_drained("R9");
    chk(err_flags == 4'b0010, "R9", int'(err_flags), 2);
    clear_flags();
    clear_pulls();

    // arbitration lost on the first header bit (R10)
    pull_mask[1] = 1'b1;
    load_byte(8'hA5, 1'b1);
    push_start(); push_bits(8'hA5, 1);
    trigger(); wait_idle();
    check_drained("R10");
    chk(err_flags == 4'b1000, "R10", int'(err_flags), 8);
    chk(!tx_busy && !line_drive_low, "R10", int'(line_drive_low), 0);
    clear_flags();
    clear_pulls();

    // mismatch in second byte: transmit error (R11)
    pull_mask[10] = 1'b1; pull_mask[11] = 1'b1;
    load_byte(8'h00, 1'b0);
    push_start(); push_byte(8'h00, 1'b0); push_bits(8'h80, 1);
    trigger(); wait_req();
    load_byte(8'h80, 1'b1);
    wait_idle();
    check_drained("R11");
    chk(err_flags == 4'b0100, "R11", int'(err_flags), 4);
    clear_pulls();

    // R12: a clean frame leaves the sticky flag set
    pull_mask[10] = 1'b1;
    load_byte(8'h55, 1'b1);
    push_start(); push_byte(8'h55, 1'b1);
    trigger(); wait_idle();
    check_drained("R12");
    chk(err_flags == 4'b0100, "R12", int'(err_flags), 4);
    clear_flags();
    chk(err_flags == 4'b0000, "R12", int'(err_flags), 0);
    clear_pulls();

    // R13: no tick holds the start bit
    mon_en = 1'b0;
    tick = 1'b0;
    trigger();
    repeat (30) @(negedge clk);
    chk(tx_busy && line_drive_low, "R13", int'(line_drive_low), 1);
    tick = 1'b1;
    wait_idle();
    chk(err_flags == 4'b0010, "R13", int'(err_flags), 2);
    clear_flags();
    repeat (3) @(negedge clk);
    mon_en = 1'b1;

    finish_run();
  end
endmodule